// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Engine

This block carries out one host-side programmed-I/O transfer on a parallel ATA bus. The transfer is either a register access or a data-port access. A requester presents one request. The request names the register, gives the direction and the write value, and says whether the 8-bit register timing or the 16-bit data timing applies. The engine then produces the chip selects, the three address lines and the two active-low strobes as one 7-bit bus control word. On a write it drives the data bus. On a read it captures the device's data.

Every phase length is a count of clock ticks, taken from configuration inputs at the moment the request is accepted. The phases are address setup, strobe active and recovery. The device may hold the ready line low to lengthen the active phase. Any time spent this way is taken out of the remaining cycle budget, not added on top of it. When recovery ends, the engine pulses `done` and is free to accept the next request.

Top module: `pio_cycle_engine`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `busCtl` equals 7'h63. `busy`, `done` and `ddOe` are all low in that state.
- R2: Field positions in `busCtl` are fixed:
  - bit0 is CS0 (active low) and bit1 is CS1 (active low).
  - bits 4:2 carry the register address.
  - bit5 is the read strobe and bit6 is the write strobe, both active low.
  - With `reqCtlBlk`=0, bit0=0 and bit1=1. With `reqCtlBlk`=1, bit0=1 and bit1=0.
  - Bits 4:0 stay constant for every cycle in which `busy` is high.
- R3: After acceptance, both strobes stay high for max(`cfgSetup`,1) ticks. The same setup value serves both timing sets.
- R4: Exactly one strobe goes low: the read strobe for a read, the write strobe for a write. With no stretch it stays low for max(active,1) ticks. The active value is `cfgAct8` when `reqIsReg`=1 and `cfgAct16` otherwise.
- R5: Stretch applies when `cfgIordyEn`=1, the synchronized ready line is low at the end of the active phase, and the active count is below CAP=(1250+35)/25=51. The strobe then stays low until ready is seen or until the total low time reaches CAP ticks. No stretch occurs when the active count is CAP or more.
- R6: Recovery after the strobe rises is (cycle − effective active) ticks when that difference is positive and greater than the minimum recovery. Otherwise recovery is the minimum recovery, with a floor of 1. The effective active time includes any stretch. The cycle and minimum-recovery values come from the same timing set as the active value.
- R7: On a read, `rdData` takes the value on `ddIn` at the clock edge where the read strobe is released. It holds that value through later cycles, including writes.
- R8: `ddOe` is high with `ddOut` equal to the request's write value for every tick the write strobe is low. It stays high for min(hold, recovery) further ticks, where hold is 3 for `cfgPioMode`=0, 2 for modes 1–2 and 1 for modes 3 and above. `ddOe` is never high for a read.
- R9: `busy` rises in the cycle after acceptance and stays high until recovery ends. `done` is high for exactly one cycle, which is the first cycle with `busy` low again.
- R10: A `reqValid` while `busy` is high is ignored. The cycle in flight keeps its address and direction, and no second cycle follows.
- R11: The ready line passes through two flops. When it rises during a stretch, the strobe is released three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIsReg | input | 1 | 1 = register timing set, 0 = data timing set |
| reqCtlBlk | input | 1 | 1 = control block (CS1 asserted), 0 = command block (CS0 asserted) |
| reqAddr | input | 3 | Register address A2..A0 |
| reqWData | input | 16 | Write value |
| cfgSetup | input | 8 | Address setup ticks |
| cfgAct8 | input | 8 | Register active ticks |
| cfgCyc8 | input | 8 | Register total cycle ticks |
| cfgRec8 | input | 8 | Register minimum recovery ticks |
| cfgAct16 | input | 8 | Data active ticks |
| cfgCyc16 | input | 8 | Data total cycle ticks |
| cfgRec16 | input | 8 | Data minimum recovery ticks |
| cfgPioMode | input | 3 | Transfer mode, selects write hold |
| cfgIordyEn | input | 1 | Enables ready-line stretching |
| iordy | input | 1 | Device ready line, asynchronous |
| ddIn | input | 16 | Data bus input |
| busCtl | output | 7 | Chip selects, address and strobes |
| ddOut | output | 16 | Data bus output value |
| ddOe | output | 1 | Data bus output enable |
| rdData | output | 16 | Captured read value |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |

## Verification
A phase counter that ends a phase too early or too late shows up at once as a wrong number of ticks between strobe edges. A miscounted stretch counter surfaces later: it corrupts recovery length only after the strobe rises, so the checker counts recovery ticks until `done`. A wrong capture point does not show until `rdData` is read after the cycle. The bench therefore changes `ddIn` right after the strobe edge so that an early or late capture returns the wrong word. A stale direction or address latch is seen in the first setup tick on `busCtl`.

// File: rtl/pio_cycle_pkg.sv
package pio_cycle_pkg;

  localparam int unsigned BUS_CTL_W = 7;
  localparam logic [BUS_CTL_W-1:0] BUS_IDLE = 7'h63;

  // Phase-level strobes from the control FSM to the datapath.
  typedef struct packed {
    logic latchReq;    // load the request and its timing set
    logic addrOn;      // chip selects and address presented
    logic strobeOn;    // the direction's strobe is low
    logic driveOn;     // write data may be driven
    logic capture;     // strobe rises at this edge
    logic stretchInc;  // one more ready-wait tick
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_STRETCH,
    PH_RECOVER
  } phase_t;

endpackage

// File: rtl/pio_iordy_sync.sv
module pio_iordy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= 1'b0;
          else       stage[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= 1'b0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pio_cycle_ctrl.sv
module pio_cycle_ctrl
  import pio_cycle_pkg::*;
#(
  parameter int unsigned EXT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             iordySync,
  input  logic [EXT_W-1:0] setupLen,
  input  logic [EXT_W-1:0] actLen,
  input  logic [EXT_W-1:0] recLen,
  input  logic [1:0]       holdLen,
  input  logic             canStretch,
  input  logic             stretchLast,
  output ctlStrobe_t       ctl,
  output logic             busy,
  output logic             done
);

  phase_t           state, stateNxt;
  logic [EXT_W-1:0] cnt;
  logic [EXT_W-1:0] lenSel;
  logic             phaseEnd;
  logic             cntClr;
  logic             doneSet;

  always_comb begin
    unique case (state)
      PH_SETUP:   lenSel = setupLen;
      PH_ACTIVE:  lenSel = actLen;
      PH_RECOVER: lenSel = recLen;
      default:    lenSel = EXT_W'(1);
    endcase
    phaseEnd = ({1'b0, cnt} + (EXT_W+1)'(1)) >= {1'b0, lenSel};
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    cntClr   = 1'b0;
    doneSet  = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateNxt     = PH_SETUP;
          cntClr       = 1'b1;
        end
      end
      PH_SETUP: begin
        ctl.addrOn = 1'b1;
        if (phaseEnd) begin
          stateNxt = PH_ACTIVE;
          cntClr   = 1'b1;
        end
      end
      PH_ACTIVE: begin
        ctl.addrOn   = 1'b1;
        ctl.strobeOn = 1'b1;
        ctl.driveOn  = 1'b1;
        if (phaseEnd) begin
          cntClr = 1'b1;
          if (canStretch && !iordySync) begin
            stateNxt = PH_STRETCH;
          end else begin
            ctl.capture = 1'b1;
            stateNxt    = PH_RECOVER;
          end
        end
      end
      PH_STRETCH: begin
        ctl.addrOn     = 1'b1;
        ctl.strobeOn   = 1'b1;
        ctl.driveOn    = 1'b1;
        ctl.stretchInc = 1'b1;
        if (iordySync || stretchLast) begin
          ctl.capture = 1'b1;
          stateNxt    = PH_RECOVER;
          cntClr      = 1'b1;
        end
      end
      PH_RECOVER: begin
        ctl.addrOn  = 1'b1;
        ctl.driveOn = (cnt < EXT_W'(holdLen));
        if (phaseEnd) begin
          stateNxt = PH_IDLE;
          doneSet  = 1'b1;
        end
      end
      default: stateNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneSet;
      if (cntClr)                cnt <= '0;
      else if (state != PH_IDLE) cnt <= cnt + EXT_W'(1);
    end
  end

  assign busy = (state != PH_IDLE);

endmodule

// File: rtl/pio_cycle_dpath.sv
module pio_cycle_dpath
  import pio_cycle_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IORDY_CAP = 51,
  localparam int unsigned EXT_W    = CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  input  logic                 reqWrite,
  input  logic                 reqIsReg,
  input  logic                 reqCtlBlk,
  input  logic [2:0]           reqAddr,
  input  logic [DATA_W-1:0]    reqWData,
  input  logic [CNT_W-1:0]     cfgSetup,
  input  logic [CNT_W-1:0]     cfgAct8,
  input  logic [CNT_W-1:0]     cfgCyc8,
  input  logic [CNT_W-1:0]     cfgRec8,
  input  logic [CNT_W-1:0]     cfgAct16,
  input  logic [CNT_W-1:0]     cfgCyc16,
  input  logic [CNT_W-1:0]     cfgRec16,
  input  logic [2:0]           cfgPioMode,
  input  logic                 cfgIordyEn,
  input  logic [DATA_W-1:0]    ddIn,
  output logic [BUS_CTL_W-1:0] busCtl,
  output logic [DATA_W-1:0]    ddOut,
  output logic                 ddOe,
  output logic [DATA_W-1:0]    rdData,
  output logic [EXT_W-1:0]     setupLen,
  output logic [EXT_W-1:0]     actLen,
  output logic [EXT_W-1:0]     recLen,
  output logic [1:0]           holdLen,
  output logic                 canStretch,
  output logic                 stretchLast
);

  localparam logic [EXT_W-1:0] CAP_V = EXT_W'(IORDY_CAP);

  function automatic logic [1:0] holdFor(input logic [2:0] mode);
    unique case (mode)
      3'd0:       return 2'd3;
      3'd1, 3'd2: return 2'd2;
      default:    return 2'd1;
    endcase
  endfunction

  function automatic logic [EXT_W-1:0] atLeastOne(input logic [EXT_W-1:0] v);
    return (v == '0) ? EXT_W'(1) : v;
  endfunction

  logic              writeQ, ctlBlkQ, iordyEnQ;
  logic [2:0]        addrQ;
  logic [DATA_W-1:0] wDataQ;
  logic [CNT_W-1:0]  setupQ, actQ, cycQ, recQ;
  logic [1:0]        holdQ;
  logic [EXT_W-1:0]  stretchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeQ   <= 1'b0;
      ctlBlkQ  <= 1'b0;
      iordyEnQ <= 1'b0;
      addrQ    <= '0;
      wDataQ   <= '0;
      setupQ   <= '0;
      actQ     <= '0;
      cycQ     <= '0;
      recQ     <= '0;
      holdQ    <= '0;
      stretchQ <= '0;
      rdData   <= '0;
    end else begin
      if (ctl.latchReq) begin
        writeQ   <= reqWrite;
        ctlBlkQ  <= reqCtlBlk;
        iordyEnQ <= cfgIordyEn;
        addrQ    <= reqAddr;
        wDataQ   <= reqWData;
        setupQ   <= cfgSetup;
        actQ     <= reqIsReg ? cfgAct8 : cfgAct16;
        cycQ     <= reqIsReg ? cfgCyc8 : cfgCyc16;
        recQ     <= reqIsReg ? cfgRec8 : cfgRec16;
        holdQ    <= holdFor(cfgPioMode);
      end
      if (ctl.latchReq)        stretchQ <= '0;
      else if (ctl.stretchInc) stretchQ <= stretchQ + EXT_W'(1);
      if (ctl.capture && !writeQ) rdData <= ddIn;
    end
  end

  logic [EXT_W-1:0] stretchLimit, effActive, cycExt, recExt, cycRemain, recRaw;

  always_comb begin
    setupLen     = atLeastOne({1'b0, setupQ});
    actLen       = atLeastOne({1'b0, actQ});
    stretchLimit = (CAP_V > actLen) ? (CAP_V - actLen) : '0;
    canStretch   = iordyEnQ && (stretchLimit != '0);
    stretchLast  = ({1'b0, stretchQ} + (EXT_W+1)'(1)) >= {1'b0, stretchLimit};
    effActive    = actLen + stretchQ;
    cycExt       = {1'b0, cycQ};
    recExt       = {1'b0, recQ};
    cycRemain    = cycExt - effActive;
    recRaw       = ((cycExt > effActive) && (cycRemain > recExt)) ? cycRemain : recExt;
    recLen       = atLeastOne(recRaw);
    holdLen      = holdQ;
  end

  always_comb begin
    if (ctl.addrOn)
      busCtl = {~(ctl.strobeOn & writeQ), ~(ctl.strobeOn & ~writeQ), addrQ, ~ctlBlkQ, ctlBlkQ};
    else
      busCtl = BUS_IDLE;
  end

  assign ddOut = wDataQ;
  assign ddOe  = ctl.driveOn & writeQ;

endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
  import pio_cycle_pkg::*;
#(
  parameter int unsigned CNT_W          = 8,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned IORDY_MAX_NS   = 1250,
  parameter int unsigned IORDY_FIRST_NS = 35,
  parameter int unsigned TICK_NS        = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIsReg,
  input  logic              reqCtlBlk,
  input  logic [2:0]        reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgAct8,
  input  logic [CNT_W-1:0]  cfgCyc8,
  input  logic [CNT_W-1:0]  cfgRec8,
  input  logic [CNT_W-1:0]  cfgAct16,
  input  logic [CNT_W-1:0]  cfgCyc16,
  input  logic [CNT_W-1:0]  cfgRec16,
  input  logic [2:0]        cfgPioMode,
  input  logic              cfgIordyEn,
  input  logic              iordy,
  input  logic [DATA_W-1:0] ddIn,
  output logic [6:0]        busCtl,
  output logic [DATA_W-1:0] ddOut,
  output logic              ddOe,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done
);

  localparam int unsigned EXT_W     = CNT_W + 1;
  localparam int unsigned IORDY_CAP = (IORDY_MAX_NS + IORDY_FIRST_NS) / TICK_NS;

  ctlStrobe_t       ctl;
  logic             iordySync;
  logic [EXT_W-1:0] setupLen, actLen, recLen;
  logic [1:0]       holdLen;
  logic             canStretch, stretchLast;

  pio_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (iordy),
    .syncOut (iordySync)
  );

  pio_cycle_ctrl #(.EXT_W(EXT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .iordySync   (iordySync),
    .setupLen    (setupLen),
    .actLen      (actLen),
    .recLen      (recLen),
    .holdLen     (holdLen),
    .canStretch  (canStretch),
    .stretchLast (stretchLast),
    .ctl         (ctl),
    .busy        (busy),
    .done        (done)
  );

  pio_cycle_dpath #(
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .IORDY_CAP (IORDY_CAP)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqWrite    (reqWrite),
    .reqIsReg    (reqIsReg),
    .reqCtlBlk   (reqCtlBlk),
    .reqAddr     (reqAddr),
    .reqWData    (reqWData),
    .cfgSetup    (cfgSetup),
    .cfgAct8     (cfgAct8),
    .cfgCyc8     (cfgCyc8),
    .cfgRec8     (cfgRec8),
    .cfgAct16    (cfgAct16),
    .cfgCyc16    (cfgCyc16),
    .cfgRec16    (cfgRec16),
    .cfgPioMode  (cfgPioMode),
    .cfgIordyEn  (cfgIordyEn),
    .ddIn        (ddIn),
    .busCtl      (busCtl),
    .ddOut       (ddOut),
    .ddOe        (ddOe),
    .rdData      (rdData),
    .setupLen    (setupLen),
    .actLen      (actLen),
    .recLen      (recLen),
    .holdLen     (holdLen),
    .canStretch  (canStretch),
    .stretchLast (stretchLast)
  );

endmodule

// File: rtl/pio_cycle_checker.sv
module pio_cycle_checker (
  input logic       clk,
  input logic       rstN,
  input logic [6:0] busCtl,
  input logic       busy,
  input logic       done,
  input logic       ddOe
);

  // R4: never both strobes low together
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!busCtl[5] && !busCtl[6]));

  // R1: idle bus word whenever no cycle runs
  a_r1_idle_word: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (busCtl == 7'h63));

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done marks the fall of busy
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R2: address and chip selects held while busy
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(busCtl[4:0]));

  // R8: bus only driven inside a cycle and never with read strobe low
  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    ddOe |-> (busy && busCtl[5]));

endmodule

bind pio_cycle_engine pio_cycle_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busCtl (busCtl),
  .busy   (busy),
  .done   (done),
  .ddOe   (ddOe)
);

// File: tb/tb_pio_cycle_engine.sv
`timescale 1ns/1ps
module tb_pio_cycle_engine;

  localparam int CAP = (1250 + 35) / 25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIsReg = 1'b0, reqCtlBlk = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic [7:0]  cfgSetup = 8'd1, cfgAct8 = 8'd1, cfgCyc8 = 8'd1, cfgRec8 = 8'd1;
  logic [7:0]  cfgAct16 = 8'd1, cfgCyc16 = 8'd1, cfgRec16 = 8'd1;
  logic [2:0]  cfgPioMode = '0;
  logic        cfgIordyEn = 1'b0;
  logic        iordy = 1'b1;
  logic [15:0] ddIn = 16'h0;
  logic [6:0]  busCtl;
  logic [15:0] ddOut, rdData;
  logic        ddOe, busy, done;

  pio_cycle_engine dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIsReg(reqIsReg), .reqCtlBlk(reqCtlBlk), .reqAddr(reqAddr), .reqWData(reqWData),
    .cfgSetup(cfgSetup), .cfgAct8(cfgAct8), .cfgCyc8(cfgCyc8), .cfgRec8(cfgRec8),
    .cfgAct16(cfgAct16), .cfgCyc16(cfgCyc16), .cfgRec16(cfgRec16),
    .cfgPioMode(cfgPioMode), .cfgIordyEn(cfgIordyEn), .iordy(iordy), .ddIn(ddIn),
    .busCtl(busCtl), .ddOut(ddOut), .ddOe(ddOe), .rdData(rdData), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;  // 250 MHz

  int compared = 0, mismatched = 0, cycles = 0, serial = 0;

  // stimulus settings for one cycle
  int tSetup, tAct8, tCyc8, tRec8, tAct16, tCyc16, tRec16, tMode, raiseAt = 0;
  bit tEn, tIordyLow, tWrite, tReg, tCtlBlk, poke = 0;
  logic [2:0] tAddr;

  // port monitor
  int setupCnt, lowCnt, recCnt, holdCnt, doneCnt;
  bit seenLow, addrBad, wrBad, oeRead;
  logic [15:0] expR, expW;
  logic [4:0]  expLow5;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        if (busCtl[4:0] != expLow5) addrBad = 1;
        if (!tWrite && ddOe) oeRead = 1;
        if (!busCtl[5] || !busCtl[6]) begin
          lowCnt++;
          seenLow = 1;
          if (!busCtl[6] && (!ddOe || ddOut != expW)) wrBad = 1;
          if (!busCtl[5]) ddIn = expR;
          if (raiseAt != 0 && lowCnt == raiseAt) iordy = 1'b1;
        end else if (!seenLow) begin
          setupCnt++;
        end else begin
          recCnt++;
          if (ddOe) holdCnt++;
          ddIn = ~expR;
        end
      end
      if (done) doneCnt++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL R9 watchdog: actual %0d cycles expected under 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run(input string tag);
    int s, a, c, r, lim, low, rec, hold, guard;
    logic [15:0] prevRd;
    s = (tSetup == 0) ? 1 : tSetup;
    a = tReg ? tAct8 : tAct16;
    if (a == 0) a = 1;
    c = tReg ? tCyc8 : tCyc16;
    r = tReg ? tRec8 : tRec16;
    lim = (CAP > a) ? CAP - a : 0;
    if (tEn && tIordyLow && lim > 0) low = (raiseAt != 0) ? raiseAt + 2 : a + lim;
    else low = a;
    rec = (c > low && c - low > r) ? c - low : r;
    if (rec == 0) rec = 1;
    hold = 0;
    if (tWrite) begin
      hold = (tMode == 0) ? 3 : ((tMode <= 2) ? 2 : 1);
      if (hold > rec) hold = rec;
    end
    @(negedge clk);
    cfgSetup = 8'(tSetup); cfgAct8 = 8'(tAct8); cfgCyc8 = 8'(tCyc8); cfgRec8 = 8'(tRec8);
    cfgAct16 = 8'(tAct16); cfgCyc16 = 8'(tCyc16); cfgRec16 = 8'(tRec16);
    cfgPioMode = 3'(tMode); cfgIordyEn = tEn;
    iordy = ~tIordyLow;
    repeat (3) @(negedge clk);
    prevRd = rdData;
    serial++;
    expR = 16'(serial * 947) ^ 16'h5a00;
    expW = ~expR ^ 16'h0f0f;
    expLow5 = {tAddr, ~tCtlBlk, tCtlBlk};
    setupCnt = 0; lowCnt = 0; recCnt = 0; holdCnt = 0; doneCnt = 0;
    seenLow = 0; addrBad = 0; wrBad = 0; oeRead = 0;
    reqValid = 1'b1; reqWrite = tWrite; reqIsReg = tReg; reqCtlBlk = tCtlBlk;
    reqAddr = tAddr; reqWData = expW;
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      reqValid = 1'b1; reqAddr = ~tAddr; reqWrite = ~tWrite; reqCtlBlk = ~tCtlBlk;
      repeat (2) @(negedge clk);
      reqValid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " R9 done reached"}, int'(guard < 3000), 1);
    chk({tag, " R9 busy low with done"}, int'(busy), 0);
    repeat (4) @(negedge clk);
    chk({tag, " R3 setup ticks"}, setupCnt, s);
    chk({tag, " R4/R5 strobe low ticks"}, lowCnt, low);
    chk({tag, " R6 recovery ticks"}, recCnt, rec);
    chk({tag, " R8 hold ticks"}, holdCnt, hold);
    chk({tag, " R8 write data on bus"}, int'(wrBad), 0);
    chk({tag, " R8 no drive on read"}, int'(oeRead), 0);
    chk({tag, " R2 address and selects"}, int'(addrBad), 0);
    chk({tag, " R10 single done"}, doneCnt, 1);
    if (!tWrite) chk({tag, " R7 captured read"}, int'(rdData), int'(expR));
    else         chk({tag, " R7 read value held"}, int'(rdData), int'(prevRd));
    raiseAt = 0;
    poke = 0;
  endtask

  task automatic defaults();
    tSetup = 1; tAct8 = 2; tCyc8 = 4; tRec8 = 1; tAct16 = 2; tCyc16 = 4; tRec16 = 1;
    tMode = 4; tEn = 0; tIordyLow = 0; tWrite = 0; tReg = 1; tCtlBlk = 0; tAddr = 3'd7;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 idle word in reset", int'(busCtl), 'h63);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle word", int'(busCtl), 'h63);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ddOe", int'(ddOe), 0);

    // main sweep over both timing sets, directions and selects (R2..R8)
    for (int reg_i = 0; reg_i < 2; reg_i++)
      for (int wr = 0; wr < 2; wr++)
        for (int su = 1; su <= 2; su++)
          for (int ac = 1; ac <= 3; ac++)
            for (int cy = 0; cy < 2; cy++)
              for (int rc = 0; rc < 2; rc++) begin
                defaults();
                tReg = bit'(reg_i); tWrite = bit'(wr); tSetup = su;
                tAct8 = ac; tAct16 = ac + 1;
                tCyc8 = cy ? 7 : 2; tCyc16 = cy ? 9 : 3;
                tRec8 = rc ? 3 : 1; tRec16 = rc ? 4 : 2;
                tMode = (serial % 5);
                tCtlBlk = bit'(serial % 2);
                tAddr = 3'(serial);
                run("sweep");
              end

    // R3 R4 R6: zero counts behave as one
    defaults();
    tSetup = 0; tAct8 = 0; tCyc8 = 0; tRec8 = 0; tWrite = 1; tMode = 0;
    run("zero counts");

    // R2: control block at address 6
    defaults();
    tCtlBlk = 1; tAddr = 3'd6; tWrite = 0;
    run("control block read");

    // R5: ready low until cap, recovery shortened by the stretch
    defaults();
    tEn = 1; tIordyLow = 1; tAct8 = 3; tCyc8 = 60; tRec8 = 2;
    run("R5 stretch to cap");
    defaults();
    tEn = 1; tIordyLow = 1; tReg = 0; tAct16 = 5; tCyc16 = 20; tRec16 = 4; tWrite = 1;
    run("R5 stretch data write");
    // R5: ready high, no stretch
    defaults();
    tEn = 1; tIordyLow = 0; tAct8 = 3; tCyc8 = 10;
    run("R5 ready high");
    // R5: stretching disabled
    defaults();
    tEn = 0; tIordyLow = 1; tAct8 = 3; tCyc8 = 10;
    run("R5 disabled");
    // R5: active already at cap
    defaults();
    tEn = 1; tIordyLow = 1; tAct8 = 60; tCyc8 = 70;
    run("R5 active past cap");

    // R11: ready rises mid-stretch
    defaults();
    tEn = 1; tIordyLow = 1; tAct8 = 2; tCyc8 = 20; raiseAt = 7;
    run("R11 ready release");

    // R10: requests while busy ignored
    defaults();
    tSetup = 4; tWrite = 1; tAddr = 3'd2;
    poke = 1;
    run("R10 busy request");

    // R8: hold per mode with long recovery
    for (int m = 0; m < 5; m++) begin
      defaults();
      tWrite = 1; tMode = m; tRec8 = 6; tCyc8 = 3;
      run("R8 mode hold");
    end

    summary();
    $finish;
  end

endmodule